// File: doc/BRIEF.md
# Static Memory Bank Timing Controller

This block runs a single external asynchronous static memory bank, such as a flash device or an SRAM, on behalf of an internal requester. The requester presents one access at a time over a valid/ready handshake. Each access carries an address, write data, byte enables and a read/write flag. The block then sequences the chip select, output enable, write enable and byte-lane pins. It returns exactly one response per memory beat, carrying read data and an error flag.

Every phase of an access lasts a number of bus clock cycles taken from its own timing input. Each timing input applies its own offset to the programmed value. The memory may be 8, 16 or 32 bits wide, and each request is a single access of that width. Chip select and the byte lanes each have a selectable polarity. An optional page mode turns one read request into a four-beat page burst, and later beats in the burst use a shorter wait. An optional wait pin can hold the final strobe cycle. Its hold time is bounded by a programmable timeout, and an access that reaches the timeout ends with an error.

Top module: `smb_ctrl`

## Requirements
- R1: On a write, chip select is active for t_cs_we+1 cycles before write enable goes low. Write enable then stays low for t_wr_wait+2 cycles, and chip select ends in the same cycle as write enable. The response (rsp_err=0, rsp_rdata=0) comes in the first cycle after chip select drops.
- R2: On a non-page read, output enable goes low t_cs_oe cycles after chip select becomes active. A value of 0 means both go active in the same cycle. Output enable stays low for t_rd_wait+1 cycles, and mem_din is captured in the last of those cycles. The response comes in the following cycle.
- R3: When cfg_page_en=1, a read produces four responses. The addresses start at the request address aligned down to four memory words and step by one memory word. The first beat waits t_rd_wait+1 cycles and each later beat waits t_pg_wait+1 cycles. Chip select and output enable stay active through the whole burst.
- R4: After chip select drops, req_ready stays low for t_turn+1 cycles and then goes high.
- R5: mem_cs is high when active if cfg_cs_high=1, and low when active if cfg_cs_high=0.
- R6: While chip select is active, the enabled lanes are driven high on reads and low on writes when cfg_lane_low=0. When cfg_lane_low=1, the enabled lanes are driven low on both reads and writes. A lane that is not enabled is driven to the opposite level. While chip select is inactive, every lane sits at the value of cfg_lane_low.
- R7: cfg_width selects the memory width: 0 is 8 bits on lane 0, 1 is 16 bits on lanes 1:0, and 2 or 3 is 32 bits on all four lanes. mem_addr is the request address aligned to the width. The enabled lanes are req_be masked to the width on writes and all width lanes on reads. Read data above the width is returned as zero.
- R8: When cfg_xwait_en=1, a high mem_wait at the last strobe cycle holds that cycle until mem_wait is low. When cfg_xwait_en=0, mem_wait has no effect on timing.
- R9: If mem_wait holds the last strobe cycle for 16*(cfg_xwait_tmo+1) consecutive cycles, the access ends at once. Its response carries rsp_err=1.
- R10: busy is high exactly while req_ready is low, which covers the access phases and the turnaround.
- R11: mem_dout_en is high and mem_dout equals the request write data throughout a write's chip-select window. mem_dout_en is low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and accepting a request |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | AW | Byte address |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte enables for writes |
| rsp_valid | output | 1 | One beat completed |
| rsp_rdata | output | 32 | Read data, zero above the width |
| rsp_err | output | 1 | Beat ended by wait timeout |
| busy | output | 1 | Access or turnaround in progress |
| cfg_width | input | 2 | Memory width code |
| cfg_cs_high | input | 1 | Chip select active-high |
| cfg_lane_low | input | 1 | Byte lanes active-low on reads and writes |
| cfg_page_en | input | 1 | Four-beat page reads |
| cfg_xwait_en | input | 1 | Honour mem_wait |
| cfg_xwait_tmo | input | 10 | Wait timeout count n, limit 16*(n+1) |
| t_cs_oe | input | 4 | Chip select to output enable, n cycles |
| t_cs_we | input | 4 | Chip select to write enable, n+1 cycles |
| t_rd_wait | input | 5 | First read wait, n+1 cycles |
| t_pg_wait | input | 5 | Later page read wait, n+1 cycles |
| t_wr_wait | input | 5 | Write strobe, n+2 cycles |
| t_turn | input | 4 | Turnaround, n+1 cycles |
| mem_addr | output | AW | Memory address |
| mem_dout | output | 32 | Memory write data |
| mem_dout_en | output | 1 | Data bus drive enable |
| mem_din | input | 32 | Memory read data |
| mem_wait | input | 1 | Memory requests wait, active high |
| mem_cs | output | 1 | Chip select, polarity per cfg_cs_high |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_lane | output | 4 | Byte-lane strobes, polarity per R6 |

## Verification
If the phase counter or its limit is off by one, the width of the output-enable or write-enable window changes on the very first access. The response cycle moves with it, so a bench that counts strobe cycles and response positions at the pins catches the error within one access. A wrong beat counter or base address in page mode shows up as the wrong number of responses, or as read data that does not match the address pattern on the second beat. A stuck or miscounted wait counter appears only when mem_wait is held long enough. It shows as a wrong chip-select length or a missing rsp_err after 16*(n+1) cycles, so the timeout is driven both just under and at its limit.

// File: rtl/smb_pkg.sv
package smb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_STROBE = 2'd2,
    ST_TURN   = 2'd3
  } smb_state_e;

  // log2 of bytes per memory word for a width code (code 3 acts as 32 bits)
  function automatic logic [1:0] width_shift(input logic [1:0] code);
    case (code)
      2'd0:    return 2'd0;
      2'd1:    return 2'd1;
      default: return 2'd2;
    endcase
  endfunction

  // lanes carried by a memory word of the given width code
  function automatic logic [3:0] width_lanes(input logic [1:0] code);
    case (code)
      2'd0:    return 4'b0001;
      2'd1:    return 4'b0011;
      default: return 4'b1111;
    endcase
  endfunction

endpackage

// File: rtl/smb_phase_len.sv
module smb_phase_len
  import smb_pkg::*;
#(
  parameter int SHORT_W = 4,
  parameter int LONG_W  = 5,
  parameter int LEN_W   = LONG_W + 1
) (
  input  smb_state_e         state,
  input  logic               is_write,
  input  logic               first_beat,
  input  logic [SHORT_W-1:0] t_cs_oe,
  input  logic [SHORT_W-1:0] t_cs_we,
  input  logic [SHORT_W-1:0] t_turn,
  input  logic [LONG_W-1:0]  t_rd_wait,
  input  logic [LONG_W-1:0]  t_pg_wait,
  input  logic [LONG_W-1:0]  t_wr_wait,
  output logic [LEN_W-1:0]   last_cnt
);

  // last_cnt is the phase length minus one
  always_comb begin
    case (state)
      ST_SETUP: begin
        if (is_write) last_cnt = LEN_W'(t_cs_we);
        else          last_cnt = LEN_W'(t_cs_oe) - LEN_W'(1);
      end
      ST_STROBE: begin
        if (is_write)        last_cnt = LEN_W'(t_wr_wait) + LEN_W'(1);
        else if (first_beat) last_cnt = LEN_W'(t_rd_wait);
        else                 last_cnt = LEN_W'(t_pg_wait);
      end
      ST_TURN:  last_cnt = LEN_W'(t_turn);
      default:  last_cnt = '0;
    endcase
  end

endmodule

// File: rtl/smb_xwait.sv
module smb_xwait #(
  parameter int TMO_W = 10,
  parameter int CNT_W = TMO_W + 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stretch,
  input  logic [TMO_W-1:0] tmo_n,
  output logic             expire
);

  logic [CNT_W-1:0] xcnt_q, xcnt_d;
  logic [CNT_W-1:0] limit_m1;

  // 16*(n+1)-1 is n followed by four ones
  assign limit_m1 = {tmo_n, 4'hF};
  assign expire   = stretch && (xcnt_q == limit_m1);

  always_comb begin
    if (stretch && !expire) xcnt_d = xcnt_q + CNT_W'(1);
    else                    xcnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) xcnt_q <= '0;
    else        xcnt_q <= xcnt_d;
  end

  AST_XWAIT_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    xcnt_q <= limit_m1); // R9

  AST_XWAIT_COUNT_ONLY_STRETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (xcnt_q != '0) |-> $past(stretch)); // R8

endmodule

// File: rtl/smb_pin_drive.sv
module smb_pin_drive #(
  parameter int LANES = 4
) (
  input  logic             cs_act,
  input  logic             oe_act,
  input  logic             we_act,
  input  logic             is_write,
  input  logic [LANES-1:0] lanes_act,
  input  logic             cfg_cs_high,
  input  logic             cfg_lane_low,
  output logic             mem_cs,
  output logic             mem_oe_n,
  output logic             mem_we_n,
  output logic [LANES-1:0] mem_lane
);

  logic lane_high_active;

  assign mem_cs           = cfg_cs_high ? cs_act : ~cs_act;
  assign mem_oe_n         = ~oe_act;
  assign mem_we_n         = ~we_act;
  assign lane_high_active = !cfg_lane_low && !is_write;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_comb begin
      if (!cs_act)               mem_lane[i] = cfg_lane_low;
      else if (lane_high_active) mem_lane[i] = lanes_act[i];
      else                       mem_lane[i] = ~lanes_act[i];
    end
  end

endmodule

// File: rtl/smb_ctrl.sv
module smb_ctrl
  import smb_pkg::*;
#(
  parameter int AW      = 24,
  parameter int TMO_W   = 10,
  parameter int SHORT_W = 4,
  parameter int LONG_W  = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [AW-1:0]      req_addr,
  input  logic [31:0]        req_wdata,
  input  logic [3:0]         req_be,
  output logic               rsp_valid,
  output logic [31:0]        rsp_rdata,
  output logic               rsp_err,
  output logic               busy,
  input  logic [1:0]         cfg_width,
  input  logic               cfg_cs_high,
  input  logic               cfg_lane_low,
  input  logic               cfg_page_en,
  input  logic               cfg_xwait_en,
  input  logic [TMO_W-1:0]   cfg_xwait_tmo,
  input  logic [SHORT_W-1:0] t_cs_oe,
  input  logic [SHORT_W-1:0] t_cs_we,
  input  logic [LONG_W-1:0]  t_rd_wait,
  input  logic [LONG_W-1:0]  t_pg_wait,
  input  logic [LONG_W-1:0]  t_wr_wait,
  input  logic [SHORT_W-1:0] t_turn,
  output logic [AW-1:0]      mem_addr,
  output logic [31:0]        mem_dout,
  output logic               mem_dout_en,
  input  logic [31:0]        mem_din,
  input  logic               mem_wait,
  output logic               mem_cs,
  output logic               mem_oe_n,
  output logic               mem_we_n,
  output logic [3:0]         mem_lane
);

  localparam int DW     = 32;
  localparam int LANES  = DW / 8;
  localparam int LEN_W  = LONG_W + 1;
  localparam int BEATS  = 4;
  localparam int BEAT_W = $clog2(BEATS);

  smb_state_e        state_q, state_d;
  logic [LEN_W-1:0]  cnt_q, cnt_d;
  logic [BEAT_W-1:0] beat_q, beat_d;
  logic              wr_q, page_q;
  logic [1:0]        wsel_q;
  logic [AW-1:0]     base_q;
  logic [DW-1:0]     wdata_q;
  logic [LANES-1:0]  be_q;
  logic              rsp_valid_q;
  logic [DW-1:0]     rsp_rdata_q;
  logic              rsp_err_q;

  logic              accept;
  logic              page_acc;
  logic [2:0]        align_acc;
  logic [AW-1:0]     amask_acc;
  logic [LEN_W-1:0]  last_cnt;
  logic              at_final;
  logic              stall;
  logic              expire;
  logic              done_beat;
  logic              more_beats;
  logic              cs_act, oe_act, we_act;
  logic [LANES-1:0]  wlanes;
  logic [LANES-1:0]  lanes_act;
  logic [DW-1:0]     dmask;

  // ---------------- request acceptance ----------------
  assign req_ready = (state_q == ST_IDLE);
  assign busy      = (state_q != ST_IDLE);
  assign accept    = req_valid && req_ready;

  assign page_acc  = cfg_page_en && !req_write;
  assign align_acc = {1'b0, width_shift(cfg_width)} + (page_acc ? 3'd2 : 3'd0);
  assign amask_acc = ~((AW'(1) << align_acc) - AW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      page_q  <= 1'b0;
      wsel_q  <= 2'd0;
      base_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
    end else if (accept) begin
      wr_q    <= req_write;
      page_q  <= page_acc;
      wsel_q  <= cfg_width;
      base_q  <= req_addr & amask_acc;
      wdata_q <= req_wdata;
      be_q    <= req_be;
    end
  end

  // ---------------- phase length and wait timeout ----------------
  smb_phase_len #(
    .SHORT_W (SHORT_W),
    .LONG_W  (LONG_W),
    .LEN_W   (LEN_W)
  ) u_len (
    .state      (state_q),
    .is_write   (wr_q),
    .first_beat (beat_q == '0),
    .t_cs_oe    (t_cs_oe),
    .t_cs_we    (t_cs_we),
    .t_turn     (t_turn),
    .t_rd_wait  (t_rd_wait),
    .t_pg_wait  (t_pg_wait),
    .t_wr_wait  (t_wr_wait),
    .last_cnt   (last_cnt)
  );

  assign at_final   = (cnt_q == last_cnt);
  assign stall      = cfg_xwait_en && mem_wait && (state_q == ST_STROBE) && at_final;
  assign done_beat  = (state_q == ST_STROBE) && at_final && (!stall || expire);
  assign more_beats = page_q && !wr_q && (beat_q != BEAT_W'(BEATS - 1)) && !expire;

  smb_xwait #(
    .TMO_W (TMO_W)
  ) u_xwait (
    .clk     (clk),
    .rst_n   (rst_n),
    .stretch (stall),
    .tmo_n   (cfg_xwait_tmo),
    .expire  (expire)
  );

  // ---------------- sequencer ----------------
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    beat_d  = beat_q;
    case (state_q)
      ST_IDLE: begin
        if (accept) begin
          cnt_d  = '0;
          beat_d = '0;
          if (!req_write && (t_cs_oe == '0)) state_d = ST_STROBE;
          else                               state_d = ST_SETUP;
        end
      end
      ST_SETUP: begin
        if (at_final) begin
          state_d = ST_STROBE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + LEN_W'(1);
        end
      end
      ST_STROBE: begin
        if (done_beat) begin
          cnt_d = '0;
          if (more_beats) beat_d = beat_q + BEAT_W'(1);
          else            state_d = ST_TURN;
        end else if (!at_final) begin
          cnt_d = cnt_q + LEN_W'(1);
        end
      end
      ST_TURN: begin
        if (at_final) begin
          state_d = ST_IDLE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + LEN_W'(1);
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      beat_q  <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      beat_q  <= beat_d;
    end
  end

  // ---------------- data path ----------------
  assign wlanes    = width_lanes(wsel_q);
  assign lanes_act = wr_q ? (be_q & wlanes) : wlanes;

  always_comb begin
    for (int i = 0; i < LANES; i++) dmask[8*i +: 8] = {8{wlanes[i]}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_err_q   <= 1'b0;
      rsp_rdata_q <= '0;
    end else begin
      rsp_valid_q <= done_beat;
      rsp_err_q   <= done_beat && expire;
      if (done_beat) rsp_rdata_q <= wr_q ? '0 : (mem_din & dmask);
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_err   = rsp_err_q;
  assign rsp_rdata = rsp_rdata_q;

  assign mem_addr    = base_q + (AW'(beat_q) << width_shift(wsel_q));
  assign mem_dout    = wdata_q;
  assign cs_act      = (state_q == ST_SETUP) || (state_q == ST_STROBE);
  assign oe_act      = !wr_q && (state_q == ST_STROBE);
  assign we_act      = wr_q && (state_q == ST_STROBE);
  assign mem_dout_en = wr_q && cs_act;

  smb_pin_drive #(
    .LANES (LANES)
  ) u_pins (
    .cs_act       (cs_act),
    .oe_act       (oe_act),
    .we_act       (we_act),
    .is_write     (wr_q),
    .lanes_act    (lanes_act),
    .cfg_cs_high  (cfg_cs_high),
    .cfg_lane_low (cfg_lane_low),
    .mem_cs       (mem_cs),
    .mem_oe_n     (mem_oe_n),
    .mem_we_n     (mem_we_n),
    .mem_lane     (mem_lane)
  );

  // ---------------- assertions ----------------
  AST_WE_NOT_WITH_CS_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_act) |-> mem_we_n); // R1

  AST_RSP_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(state_q == ST_STROBE)); // R2

  AST_BEAT_ONLY_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_q != '0) |-> (page_q && !wr_q)); // R3

  AST_TURN_AFTER_CS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_act) |-> !req_ready); // R4

  AST_ERR_WITH_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_valid); // R9

  AST_NO_STROBE_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n)); // R2

endmodule

// File: tb/tb_smb_ctrl.sv
module tb_smb_ctrl;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic        req_ready;
  logic [23:0] req_addr;
  logic [31:0] req_wdata;
  logic [3:0]  req_be;
  logic        rsp_valid, rsp_err, busy;
  logic [31:0] rsp_rdata;
  logic [1:0]  cfg_width;
  logic        cfg_cs_high, cfg_lane_low, cfg_page_en, cfg_xwait_en;
  logic [9:0]  cfg_xwait_tmo;
  logic [3:0]  t_cs_oe, t_cs_we, t_turn;
  logic [4:0]  t_rd_wait, t_pg_wait, t_wr_wait;
  logic [23:0] mem_addr;
  logic [31:0] mem_dout, mem_din;
  logic        mem_dout_en, mem_wait, mem_cs, mem_oe_n, mem_we_n;
  logic [3:0]  mem_lane;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk; // 50 MHz

  function automatic logic [31:0] memf(input logic [23:0] a);
    return ({8'h0, a} * 32'h9E3779B1) ^ 32'h13579BDF;
  endfunction

  assign mem_din = memf(mem_addr);

  smb_ctrl dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .busy(busy),
    .cfg_width(cfg_width), .cfg_cs_high(cfg_cs_high), .cfg_lane_low(cfg_lane_low),
    .cfg_page_en(cfg_page_en), .cfg_xwait_en(cfg_xwait_en), .cfg_xwait_tmo(cfg_xwait_tmo),
    .t_cs_oe(t_cs_oe), .t_cs_we(t_cs_we), .t_rd_wait(t_rd_wait), .t_pg_wait(t_pg_wait),
    .t_wr_wait(t_wr_wait), .t_turn(t_turn),
    .mem_addr(mem_addr), .mem_dout(mem_dout), .mem_dout_en(mem_dout_en), .mem_din(mem_din),
    .mem_wait(mem_wait), .mem_cs(mem_cs), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_lane(mem_lane)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int wshift(input logic [1:0] c);
    return (c == 2'd0) ? 0 : (c == 2'd1) ? 1 : 2;
  endfunction

  function automatic logic [3:0] wlanes(input logic [1:0] c);
    return (c == 2'd0) ? 4'b0001 : (c == 2'd1) ? 4'b0011 : 4'b1111;
  endfunction

  function automatic logic [31:0] dmask(input logic [1:0] c);
    return (c == 2'd0) ? 32'h0000_00FF : (c == 2'd1) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
  endfunction

  // expected lane pins while chip select is active (R6, R7)
  function automatic logic [3:0] exp_lane(input bit wr, input logic [3:0] be);
    logic [3:0] act;
    act = wr ? (be & wlanes(cfg_width)) : wlanes(cfg_width);
    if (!cfg_lane_low && !wr) return act;
    return ~act;
  endfunction

  task automatic run_access(input bit wr, input logic [23:0] addr, input logic [31:0] wd,
                            input logic [3:0] be, input int wend);
    int setup, slen, lim, nb, p, exp_cs, bytes;
    bit pg, exp_err;
    int exp_t[4];
    logic [23:0] base;
    int cs_cnt, st_first, st_cnt, turn_cnt, nrsp;
    int lane_bad, addr_bad, dout_bad, busy_bad;
    int rsp_t[4];
    logic [31:0] rsp_d[4];
    bit rsp_e[4];
    bit cs_done;

    setup = wr ? int'(t_cs_we) + 1 : int'(t_cs_oe);
    slen  = wr ? int'(t_wr_wait) + 2 : int'(t_rd_wait) + 1;
    pg    = cfg_page_en && !wr;
    lim   = 16 * (int'(cfg_xwait_tmo) + 1);
    nb    = pg ? 4 : 1;
    bytes = 1 << wshift(cfg_width);
    base  = addr & ~(24'(pg ? 4 * bytes : bytes) - 24'd1);
    exp_err = 1'b0;
    if (pg) begin
      exp_cs = setup + slen + 3 * (int'(t_pg_wait) + 1);
      for (int k = 0; k < 4; k++) exp_t[k] = setup + slen + k * (int'(t_pg_wait) + 1);
    end else begin
      p = setup + slen - 1;
      if (cfg_xwait_en && wend > p) begin
        if (wend - p >= lim) begin exp_cs = p + lim; exp_err = 1'b1; end
        else exp_cs = wend + 1;
      end else exp_cs = p + 1;
      exp_t[0] = exp_cs;
    end

    cs_cnt = 0; st_first = -1; st_cnt = 0; turn_cnt = 0; nrsp = 0;
    lane_bad = 0; addr_bad = 0; dout_bad = 0; busy_bad = 0; cs_done = 0;

    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = wd; req_be = be;
    @(negedge clk);
    req_valid = 1'b0;
    for (int t = 0; t < 20000; t++) begin
      bit cs_now, st_now;
      cs_now = (mem_cs == cfg_cs_high);
      st_now = wr ? !mem_we_n : !mem_oe_n;
      mem_wait = cs_now && (t < wend);
      if (busy != !req_ready) busy_bad++;
      if (cs_now) begin
        cs_cnt++;
        if (mem_lane != exp_lane(wr, be)) lane_bad++;
        if (t == 0 && mem_addr != base) addr_bad++;
        if (mem_dout_en != wr || (wr && mem_dout != wd)) dout_bad++;
        if (st_now) begin
          if (st_first < 0) st_first = t;
          st_cnt++;
        end
      end else begin
        if (mem_lane != {4{cfg_lane_low}}) lane_bad++;
        if (mem_dout_en) dout_bad++;
      end
      if (rsp_valid) begin
        if (nrsp < 4) begin rsp_t[nrsp] = t; rsp_d[nrsp] = rsp_rdata; rsp_e[nrsp] = rsp_err; end
        nrsp++;
      end
      if (!cs_now && t > 0) cs_done = 1'b1;
      if (cs_done) begin
        if (req_ready) break;
        turn_cnt++;
      end
      @(negedge clk);
    end
    mem_wait = 1'b0;

    chk(cs_cnt == exp_cs, wr ? "R1 cs length" : "R2/R8 cs length", cs_cnt, exp_cs);
    chk(st_first == setup, wr ? "R1 cs-to-we delay" : "R2 cs-to-oe delay", st_first, setup);
    chk(st_cnt == exp_cs - setup, wr ? "R1 we length" : "R2 oe length", st_cnt, exp_cs - setup);
    chk(turn_cnt == int'(t_turn) + 1, "R4 turnaround", turn_cnt, int'(t_turn) + 1);
    chk(nrsp == nb, pg ? "R3 beat count" : "R2 response count", nrsp, nb);
    for (int k = 0; k < nb && k < nrsp; k++) begin
      logic [31:0] ed;
      ed = wr ? 32'h0 : (memf(base + 24'(k * bytes)) & dmask(cfg_width));
      chk(rsp_t[k] == exp_t[k], pg ? "R3 beat timing" : "R2 response timing", rsp_t[k], exp_t[k]);
      chk(rsp_d[k] == ed, pg ? "R3 beat data" : "R7 read data", rsp_d[k], ed);
      chk(rsp_e[k] == exp_err, "R9 error flag", rsp_e[k], exp_err);
    end
    chk(lane_bad == 0, "R6 lane levels", lane_bad, 0);
    chk(addr_bad == 0, "R7 address alignment", addr_bad, 0);
    chk(dout_bad == 0, "R11 write data drive", dout_bad, 0);
    chk(busy_bad == 0, "R10 busy", busy_bad, 0);
  endtask

  task automatic set_timing(input int oe, input int we, input int rd, input int pg,
                            input int wrw, input int tn);
    t_cs_oe = 4'(oe); t_cs_we = 4'(we); t_rd_wait = 5'(rd);
    t_pg_wait = 5'(pg); t_wr_wait = 5'(wrw); t_turn = 4'(tn);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    req_be = '0; mem_wait = 1'b0;
    cfg_width = 2'd2; cfg_cs_high = 1'b0; cfg_lane_low = 1'b1; cfg_page_en = 1'b0;
    cfg_xwait_en = 1'b0; cfg_xwait_tmo = 10'd0;
    set_timing(2, 1, 3, 1, 2, 1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk(mem_cs == 1'b1, "R5 idle chip select", mem_cs, 1);
    chk(mem_oe_n && mem_we_n, "R2 idle strobes", {mem_oe_n, mem_we_n}, 3);
    chk(mem_lane == 4'hF, "R6 idle lanes", mem_lane, 15);
    chk(req_ready && !busy && !rsp_valid, "R10 idle status", {req_ready, busy, rsp_valid}, 4);

    // basic 32-bit read and write
    run_access(1'b0, 24'h001234, 32'h0, 4'h0, 0);
    run_access(1'b1, 24'h002000, 32'hCAFE_F00D, 4'b1010, 0);
    // zero output-enable delay
    set_timing(0, 0, 0, 0, 0, 0);
    run_access(1'b0, 24'h000103, 32'h0, 4'h0, 0);
    run_access(1'b1, 24'h000104, 32'h1111_2222, 4'hF, 0);
    // widths and lane polarity
    set_timing(1, 2, 2, 1, 1, 2);
    cfg_lane_low = 1'b0;
    cfg_width = 2'd0; run_access(1'b0, 24'h0ABC_D7, 32'h0, 4'h0, 0);
    run_access(1'b1, 24'h000011, 32'h0000_00A5, 4'b1111, 0);
    cfg_width = 2'd1; run_access(1'b0, 24'h00_1237, 32'h0, 4'h0, 0);
    run_access(1'b1, 24'h000046, 32'h0000_BEEF, 4'b0010, 0);
    cfg_width = 2'd3; run_access(1'b0, 24'h00_5557, 32'h0, 4'h0, 0);
    // chip select active high
    cfg_cs_high = 1'b1; cfg_width = 2'd2;
    run_access(1'b0, 24'h000800, 32'h0, 4'h0, 0);
    run_access(1'b1, 24'h000804, 32'h5A5A_5A5A, 4'b0110, 0);
    // page mode
    cfg_page_en = 1'b1; set_timing(2, 1, 4, 1, 1, 1);
    run_access(1'b0, 24'h00_1238, 32'h0, 4'h0, 0);
    cfg_width = 2'd1; run_access(1'b0, 24'h00_0ACE, 32'h0, 4'h0, 0);
    run_access(1'b1, 24'h00_0AC0, 32'h7777_8888, 4'b0011, 0);
    cfg_page_en = 1'b0; cfg_width = 2'd2;
    // wait pin ignored, honoured, and timing out
    run_access(1'b0, 24'h000300, 32'h0, 4'h0, 40);
    cfg_xwait_en = 1'b1; cfg_xwait_tmo = 10'd1;
    run_access(1'b0, 24'h000300, 32'h0, 4'h0, 20);
    run_access(1'b1, 24'h000304, 32'h1234_5678, 4'hF, 30);
    run_access(1'b0, 24'h000308, 32'h0, 4'h0, 1000);
    cfg_xwait_tmo = 10'd0;
    run_access(1'b1, 24'h00030C, 32'h9999_0000, 4'hF, 1000);

    // constrained random
    for (int n = 0; n < 80; n++) begin
      bit wr;
      int wend;
      cfg_width = 2'($urandom % 4); cfg_cs_high = 1'($urandom % 2);
      cfg_lane_low = 1'($urandom % 2); cfg_page_en = (($urandom % 4) == 0);
      cfg_xwait_en = 1'($urandom % 2); cfg_xwait_tmo = 10'($urandom % 3);
      set_timing($urandom % 16, $urandom % 16, $urandom % 32, $urandom % 32,
                 $urandom % 32, $urandom % 16);
      wr = 1'($urandom % 2);
      wend = (cfg_page_en && !wr) ? 0 : int'($urandom % 90);
      run_access(wr, 24'($urandom), $urandom, 4'($urandom), wend);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule